// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where execution goes after a control-transfer instruction. It takes the current 64-bit program counter, the 32-bit instruction word and the two 64-bit operand values read from the register file. From these it produces the next program counter, a taken flag and a return-address write request for the register file. It is purely combinational and sits between operand read and PC update.

Conditional branches test one register against zero or test its least significant bit. A taken branch goes to a word-aligned target relative to the sequential address PC+4. A jump goes to the address held in a second register and saves PC+4 in the first register, unless that register is the hard-wired zero register. Any other opcode just steps to PC+4.

Top module: `nextpc_unit`

## Requirements
- R1: For any opcode that is neither a branch (bits [31:26] = 3'b111 followed by a 3-bit condition code) nor a jump (bits [31:26] = 6'h1A), next_pc_o is pc_i+4, taken_o is 0 and link_we_o is 0.
- R2: Branch condition codes in bits [28:26] are signed tests of the Ra operand against zero: 1 equal, 5 not equal, 7 greater, 6 greater-or-equal, 2 less, 3 less-or-equal.
- R3: Condition code 0 is taken when bit 0 of the Ra operand is clear, and code 4 when it is set.
- R4: A taken branch sets next_pc_o to pc_i+4 plus the sign-extended displacement in bits [20:0] times 4. Ra is in bits [25:21].
- R5: A branch whose condition fails sets next_pc_o to pc_i+4 with taken_o 0, and no branch ever asserts link_we_o.
- R6: A jump always sets taken_o and sets next_pc_o to the Rb operand (index in bits [20:16]) with its two low bits cleared.
- R7: A jump asserts link_we_o with link_idx_o equal to Ra and link_data_o equal to pc_i+4, except when Ra is 31, in which case link_we_o stays 0.
- R8: Register index 31 reads as zero whatever value is on the operand port. A branch-if-equal on it is always taken, and a jump through it goes to address 0.
- R9: The jump hint field, bits [15:0], has no effect on any output.
- R10: All address sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Current program counter |
| insn_i | input | 32 | Instruction word |
| ra_val_i | input | 64 | Value read for Ra |
| rb_val_i | input | 64 | Value read for Rb |
| next_pc_o | output | 64 | Next program counter |
| taken_o | output | 1 | Control left the sequential path |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address destination register |
| link_data_o | output | 64 | Return address (PC+4) |

## Verification
Random operands are drawn mostly from the values at which the eight tests change their result: zero, one, minus one, the most negative value, and odd and even random words. This shows whether sign, zero and low-bit handling are mixed up. Random displacements reach both signs and the extreme values, so that sign extension and scaling can be told apart from plain addition. Directed cases cover the zero register on both operand ports, jumps with and without a saved link, hint-only changes, and a PC at the top of the address space that shows wrap-around.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int INSN_W = 32;
  localparam int OPC_W  = 6;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h1A;
  localparam logic [2:0]       BR_GROUP  = 3'b111;

  typedef enum logic [2:0] {
    C_LBC = 3'd0, C_EQ = 3'd1, C_LT = 3'd2, C_LE = 3'd3,
    C_LBS = 3'd4, C_NE = 3'd5, C_GE = 3'd6, C_GT = 3'd7
  } br_cond_e;

  function automatic logic cond_hit(br_cond_e c, logic z, logic n, logic l);
    case (c)
      C_LBC:   return !l;
      C_EQ:    return z;
      C_LT:    return n;
      C_LE:    return n | z;
      C_LBS:   return l;
      C_NE:    return !z;
      C_GE:    return !n;
      default: return !n && !z;
    endcase
  endfunction
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  input  br_cond_e        cond_i,
  output logic            take_o
);
  localparam int NCOND = 8;

  logic is_zero, is_neg, lsb;
  logic [NCOND-1:0] hit;

  assign is_zero = (val_i == '0);
  assign is_neg  = val_i[XLEN-1];
  assign lsb     = val_i[0];

  for (genvar g = 0; g < NCOND; g++) begin : g_test
    assign hit[g] = cond_hit(br_cond_e'(g), is_zero, is_neg, lsb);
  end

  assign take_o = hit[cond_i];

  always_comb begin
    assert_eq_ne_excl_R2: assert (hit[C_EQ] != hit[C_NE]);
    assert_lt_ge_excl_R2: assert (hit[C_LT] != hit[C_GE]);
    assert_le_cover_R2:   assert (hit[C_LE] == (hit[C_LT] | hit[C_EQ]));
    assert_lowbit_excl_R3: assert (hit[C_LBC] != hit[C_LBS]);
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 21
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   jreg_i,
  output logic [XLEN-1:0]   seq_o,
  output logic [XLEN-1:0]   br_tgt_o,
  output logic [XLEN-1:0]   jmp_tgt_o
);
  localparam int SH    = 2;
  localparam int EXT_W = XLEN - DISP_W - SH;

  logic [XLEN-1:0] offset;

  assign seq_o     = pc_i + XLEN'(1 << SH);
  assign offset    = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, {SH{1'b0}}};
  assign br_tgt_o  = seq_o + offset;
  assign jmp_tgt_o = {jreg_i[XLEN-1:SH], {SH{1'b0}}};

  always_comb begin
    assert_jmp_aligned_R6: assert (jmp_tgt_o[SH-1:0] == '0);
    assert_br_step_R4:     assert ((br_tgt_o[SH-1:0] == seq_o[SH-1:0]));
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import npc_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5,
  parameter int DISP_W = 21
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_data_o
);
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int RA_LSB  = OPC_LSB - RIDX_W;
  localparam int RB_LSB  = RA_LSB - RIDX_W;
  localparam logic [RIDX_W-1:0] ZERO_IDX = '1;

  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] ra_idx, rb_idx;
  logic [XLEN-1:0]   ra_eff, rb_eff;
  logic [XLEN-1:0]   seq, br_tgt, jmp_tgt;
  logic              is_br, is_jmp, br_take;
  br_cond_e          cond;

  assign opc    = insn_i[INSN_W-1:OPC_LSB];
  assign ra_idx = insn_i[OPC_LSB-1:RA_LSB];
  assign rb_idx = insn_i[RA_LSB-1:RB_LSB];
  assign cond   = br_cond_e'(opc[2:0]);
  assign is_br  = (opc[OPC_W-1:3] == BR_GROUP);
  assign is_jmp = (opc == OPC_JUMP);

  // hard-wired zero register
  assign ra_eff = (ra_idx == ZERO_IDX) ? '0 : ra_val_i;
  assign rb_eff = (rb_idx == ZERO_IDX) ? '0 : rb_val_i;

  npc_cond_eval #(.XLEN(XLEN)) i_cond (
    .val_i (ra_eff),
    .cond_i(cond),
    .take_o(br_take)
  );

  npc_target_gen #(.XLEN(XLEN), .DISP_W(DISP_W)) i_tgt (
    .pc_i     (pc_i),
    .disp_i   (insn_i[DISP_W-1:0]),
    .jreg_i   (rb_eff),
    .seq_o    (seq),
    .br_tgt_o (br_tgt),
    .jmp_tgt_o(jmp_tgt)
  );

  always_comb begin
    taken_o   = 1'b0;
    next_pc_o = seq;
    if (is_jmp) begin
      taken_o   = 1'b1;
      next_pc_o = jmp_tgt;
    end else if (is_br && br_take) begin
      taken_o   = 1'b1;
      next_pc_o = br_tgt;
    end
  end

  assign link_we_o   = is_jmp && (ra_idx != ZERO_IDX);
  assign link_idx_o  = ra_idx;
  assign link_data_o = seq;

  always_comb begin
    assert_link_implies_taken_R7: assert (!link_we_o || taken_o);
    assert_link_not_zero_R7:      assert (!link_we_o || link_idx_o != ZERO_IDX);
    assert_link_value_R7:         assert (!link_we_o || link_data_o == pc_i + XLEN'(4));
    assert_fallthrough_R5:        assert (taken_o || next_pc_o == pc_i + XLEN'(4));
  end
endmodule

// File: tb/test_nextpc_unit.sv
`timescale 1ns/1ps
module test_nextpc_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] pc, ra_v, rb_v, next_pc, link_data;
  logic [31:0] insn;
  logic        taken, link_we;
  logic [4:0]  link_idx;

  int n_chk = 0;
  int n_err = 0;

  nextpc_unit i_nextpc_unit (
    .pc_i(pc), .insn_i(insn), .ra_val_i(ra_v), .rb_val_i(rb_v),
    .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
    .link_idx_o(link_idx), .link_data_o(link_data)
  );

  logic [63:0] e_next;
  logic        e_taken, e_we;
  string       tag;

  function automatic logic model_cond(logic [2:0] c, logic [63:0] v);
    logic signed [63:0] s = v;
    case (c)
      3'd0: return v[0] == 1'b0;
      3'd1: return s == 0;
      3'd2: return s < 0;
      3'd3: return s <= 0;
      3'd4: return v[0] == 1'b1;
      3'd5: return s != 0;
      3'd6: return s >= 0;
      default: return s > 0;
    endcase
  endfunction

  task automatic model();
    logic [5:0]  op = insn[31:26];
    logic [4:0]  ra = insn[25:21];
    logic [4:0]  rb = insn[20:16];
    logic [63:0] a = (ra == 5'd31) ? 64'd0 : ra_v;
    logic [63:0] b = (rb == 5'd31) ? 64'd0 : rb_v;
    logic signed [63:0] d = 64'(signed'(insn[20:0]));
    e_next = pc + 64'd4; e_taken = 1'b0; e_we = 1'b0; tag = "R1";
    if (op == 6'h1A) begin
      e_taken = 1'b1; e_next = b & ~64'd3; e_we = (ra != 5'd31); tag = "R6/R7";
    end else if (op[5:3] == 3'b111) begin
      tag = (op[1:0] == 2'b00) ? "R3" : "R2";
      if (model_cond(op[2:0], a)) begin
        e_taken = 1'b1; e_next = pc + 64'd4 + (d * 4); tag = {tag, "/R4"};
      end else tag = {tag, "/R5"};
    end
  endtask

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic apply(string extra, logic [63:0] p, logic [31:0] w, logic [63:0] a, logic [63:0] b);
    @(posedge clk);
    pc = p; insn = w; ra_v = a; rb_v = b;
    @(negedge clk);
    model();
    if (extra != "") tag = {tag, "/", extra};
    chk(tag, "next_pc", next_pc, e_next);
    chk(tag, "taken", 64'(taken), 64'(e_taken));
    chk(tag, "link_we", 64'(link_we), 64'(e_we));
    if (e_we) begin
      chk(tag, "link_idx", 64'(link_idx), 64'(insn[25:21]));
      chk(tag, "link_data", link_data, p + 64'd4);
    end
  endtask

  function automatic logic [63:0] pick_val();
    case ($urandom_range(0, 6))
      0: return 64'd0;
      1: return 64'd1;
      2: return '1;
      3: return 64'h8000_0000_0000_0000;
      4: return {$urandom(), $urandom()} | 64'd1;
      5: return {$urandom(), $urandom()} & ~64'd1;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  function automatic logic [5:0] pick_op();
    logic [5:0] o;
    case ($urandom_range(0, 3))
      0, 1: return {3'b111, 3'($urandom_range(0, 7))};
      2: return 6'h1A;
      default: begin
        o = 6'($urandom_range(0, 55));
        if (o == 6'h1A) o = 6'h10;
        return o;
      end
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    pc = '0; insn = '0; ra_v = '0; rb_v = '0;
    @(negedge clk);
    // idle state: all-zero inputs step to 4
    chk("R1", "idle next_pc", next_pc, 64'd4);
    chk("R1", "idle taken", 64'(taken), 64'd0);

    // R8: beq on r31 with garbage on port is taken
    apply("R8", 64'h1000, {6'h39, 5'd31, 21'd5}, '1, 64'd0);
    // R8: jump through r31 goes to 0, r31 link suppressed (R7)
    apply("R8", 64'h2000, {6'h1A, 5'd31, 5'd31, 16'h0}, 64'd7, 64'hDEAD_BEEF);
    // R7: subroutine call keeps link in r26
    apply("R7", 64'h3000, {6'h1A, 5'd26, 5'd1, 16'h4000}, 64'd0, 64'h0000_0000_0012_3457);
    // R9: hint variations give the same result
    apply("R9", 64'h3000, {6'h1A, 5'd26, 5'd1, 16'hFFFF}, 64'd0, 64'h0000_0000_0012_3457);
    apply("R9", 64'h3000, {6'h1A, 5'd26, 5'd1, 16'h8001}, 64'd0, 64'h0000_0000_0012_3457);
    // R4: extreme displacements
    apply("R4", 64'h10_0000, {6'h3D, 5'd2, 21'h100000}, 64'd9, 64'd0);
    apply("R4", 64'h10_0000, {6'h3D, 5'd2, 21'h0FFFFF}, 64'd9, 64'd0);
    // R10: wrap at top of address space
    apply("R10", 64'hFFFF_FFFF_FFFF_FFFC, 32'h0400_0000, 64'd0, 64'd0);
    apply("R10", 64'hFFFF_FFFF_FFFF_FFF8, {6'h39, 5'd3, 21'd2}, 64'd0, 64'd0);
    // R2: gt on most negative is not taken; ge on zero taken
    apply("R2", 64'h400, {6'h3F, 5'd4, 21'd8}, 64'h8000_0000_0000_0000, 64'd0);
    apply("R2", 64'h400, {6'h3E, 5'd4, 21'd8}, 64'd0, 64'd0);
    // R3: low-bit tests on odd negative value
    apply("R3", 64'h800, {6'h3C, 5'd4, 21'h1FFFFF}, 64'hFFFF_FFFF_FFFF_FFF3, 64'd0);
    apply("R3", 64'h800, {6'h38, 5'd4, 21'h1FFFFF}, 64'hFFFF_FFFF_FFFF_FFF3, 64'd0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] w = $urandom();
      w[31:26] = pick_op();
      if ($urandom_range(0, 7) == 0) w[25:21] = 5'd31;
      apply("", {$urandom(), $urandom()} & ~64'd3, w, pick_val(), pick_val());
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule